// File: doc/BRIEF.md
# Programmable Bus Wait-State Generator

This block decides when an external bus access may finish. A bus controller pulses `acc_start` in the cycle that an access begins. The block holds a small control register with two fields: a 3-bit wait count and a 2-bit mode. At each access start it copies both fields into working state. A loadable down-counter then produces an active-low software ready. The selected mode merges that software ready with the active-low external ready pin `ext_rdy_n` and drives `rdy_int_n`.

While `rdy_int_n` is 1 the controller holds the access. When it is 0 the access completes. The counter starts from the loaded count, steps down once per clock and then rests at zero, so a count of N inserts N software wait states. After reset the register asks for seven counter-driven wait states on every access, which suits slow memories until software lowers the count.

Top module: `bus_wait_gen`

## Requirements
- R1: Mode code 2'b00 (external only): `rdy_int_n` equals `ext_rdy_n` in every cycle of the access, whatever the loaded count.
- R2: Mode code 2'b01 (counter only): `rdy_int_n` equals the software ready, and `ext_rdy_n` has no effect.
- R3: Mode code 2'b10 (both): `rdy_int_n` is 0 only in cycles where the software ready and `ext_rdy_n` are both 0.
- R4: Mode code 2'b11 (either): `rdy_int_n` is 0 in any cycle where the software ready or `ext_rdy_n` is 0.
- R5: When `acc_start` is sampled at an edge with a stored count of N (0 to 7), the software ready is 1 in the first N cycles after that edge and 0 from cycle N+1 on.
- R6: A stored count of 0 makes the software ready 0 in the first cycle after the start edge, so no software wait state is added.
- R7: Once the counter reaches zero it stays there until the next `acc_start`. An `acc_start` during a countdown reloads the counter from the stored count.
- R8: After reset the register holds mode 2'b01 with count 7, and `rdy_int_n` is 0 while no access is running.
- R9: A register write (`cfg_we` with `cfg_count`, `cfg_mode`) takes effect only at the next `acc_start` after the write edge. A write during an access, or in the same cycle as `acc_start`, does not change the count or mode of that access.
- R10: Reset is synchronous and active high. It restores the R8 state at the next rising edge and aborts any countdown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_start | input | 1 | One-cycle pulse marking the first cycle of an external access |
| ext_rdy_n | input | 1 | External ready, active low |
| cfg_we | input | 1 | Control register write enable |
| cfg_count | input | CNT_W | Wait count value to write |
| cfg_mode | input | 2 | Mode code to write (00 ext, 01 counter, 10 both, 11 either) |
| rdy_int_n | output | 1 | Internal ready, active low. 1 holds the access, 0 lets it complete |

## Verification
A register write is visible only from the next edge. The count and mode it carries apply from the edge that samples the next `acc_start`. The software ready is due in cycle 1 to N+1 after that edge. `ext_rdy_n` reaches `rdy_int_n` in the same cycle with no register in between. The bench drives inputs 1 ns after a rising edge and samples 1 ns later, then counts the cycles from the start edge until `rdy_int_n` first reads 0, and compares that count with the expected number of wait states. Reset and register writes are checked at the edge after they are applied: in the cycle before that edge the old behaviour must still be seen, and in the cycle after it the new one.

// File: rtl/bwg_pkg.sv
package bwg_pkg;
  typedef enum logic [1:0] {
    WM_EXT = 2'b00,
    WM_CNT = 2'b01,
    WM_AND = 2'b10,
    WM_OR  = 2'b11
  } wait_mode_e;
endpackage

// File: rtl/bwg_cfg_reg.sv
module bwg_cfg_reg #(
  parameter int              CNT_W    = 3,
  parameter logic [CNT_W-1:0] RST_CNT = '1,
  parameter logic [1:0]      RST_MODE = 2'b01
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CNT_W-1:0] wr_count,
  input  logic [1:0]       wr_mode,
  output logic [CNT_W-1:0] count_q,
  output logic [1:0]       mode_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= RST_CNT;
      mode_q  <= RST_MODE;
    end else if (we) begin
      count_q <= wr_count;
      mode_q  <= wr_mode;
    end
  end

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !we |=> ($stable(count_q) && $stable(mode_q)));

  // R9
  cfg_take_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> (count_q == $past(wr_count) && mode_q == $past(wr_mode)));
endmodule

// File: rtl/bwg_wait_counter.sv
module bwg_wait_counter #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             cnt_rdy_n
);
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                 cnt_q <= ZERO;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != ZERO)  cnt_q <= cnt_q - ONE;
  end

  assign cnt_rdy_n = (cnt_q != ZERO);

  // R5
  cnt_load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == $past(load_val)));

  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q != ZERO) |=> (cnt_q == $past(cnt_q) - ONE));

  // R7
  cnt_rest_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q == ZERO) |=> (cnt_q == ZERO));
endmodule

// File: rtl/bwg_ready_mux.sv
module bwg_ready_mux
  import bwg_pkg::*;
(
  input  wait_mode_e mode,
  input  logic       cnt_rdy_n,
  input  logic       ext_rdy_n,
  output logic       rdy_n
);
  always_comb begin
    unique case (mode)
      WM_EXT:  rdy_n = ext_rdy_n;
      WM_CNT:  rdy_n = cnt_rdy_n;
      WM_AND:  rdy_n = cnt_rdy_n | ext_rdy_n;
      default: rdy_n = cnt_rdy_n & ext_rdy_n;
    endcase
  end
endmodule

// File: rtl/bus_wait_gen.sv
module bus_wait_gen
  import bwg_pkg::*;
#(
  parameter int              CNT_W    = 3,
  parameter logic [CNT_W-1:0] RST_CNT = '1,
  parameter logic [1:0]      RST_MODE = 2'b01
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_start,
  input  logic             ext_rdy_n,
  input  logic             cfg_we,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic [1:0]       cfg_mode,
  output logic             rdy_int_n
);
  logic [CNT_W-1:0] reg_count;
  logic [1:0]       reg_mode;
  logic [1:0]       act_mode_q;
  logic             cnt_rdy_n;

  bwg_cfg_reg #(.CNT_W(CNT_W), .RST_CNT(RST_CNT), .RST_MODE(RST_MODE)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .we       (cfg_we),
    .wr_count (cfg_count),
    .wr_mode  (cfg_mode),
    .count_q  (reg_count),
    .mode_q   (reg_mode)
  );

  // Mode in force for the running access, captured with the count.
  always_ff @(posedge clk) begin
    if (rst)            act_mode_q <= RST_MODE;
    else if (acc_start) act_mode_q <= reg_mode;
  end

  bwg_wait_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .load      (acc_start),
    .load_val  (reg_count),
    .cnt_rdy_n (cnt_rdy_n)
  );

  bwg_ready_mux u_mux (
    .mode      (wait_mode_e'(act_mode_q)),
    .cnt_rdy_n (cnt_rdy_n),
    .ext_rdy_n (ext_rdy_n),
    .rdy_n     (rdy_int_n)
  );

  // R6
  zero_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_start && reg_count == '0 && reg_mode == WM_CNT) |=> !rdy_int_n);

  // R3
  both_block_chk: assert property (@(posedge clk) disable iff (rst)
    (act_mode_q == WM_AND && ext_rdy_n) |-> rdy_int_n);

  // R4
  either_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (act_mode_q == WM_OR && !ext_rdy_n) |-> !rdy_int_n);

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !acc_start |=> $stable(act_mode_q));
endmodule

// File: tb/bus_wait_gen_bench.sv
module bus_wait_gen_bench;
  localparam int CNT_W = 3;
  localparam int NEVER = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic acc_start = 1'b0;
  logic ext_rdy_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [CNT_W-1:0] cfg_count = '0;
  logic [1:0] cfg_mode = 2'b00;
  logic rdy_int_n;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  bus_wait_gen #(.CNT_W(CNT_W)) u_bus_wait_gen (
    .clk(clk), .rst(rst), .acc_start(acc_start), .ext_rdy_n(ext_rdy_n),
    .cfg_we(cfg_we), .cfg_count(cfg_count), .cfg_mode(cfg_mode),
    .rdy_int_n(rdy_int_n)
  );

  // {mode[9:8], count[7:5], ext[4], expected waits[3:0]}
  localparam logic [9:0] VEC [12] = '{
    {2'b00, 3'd5, 1'b0, 4'd0},   // R1
    {2'b00, 3'd5, 1'b1, 4'd10},  // R1
    {2'b01, 3'd3, 1'b1, 4'd3},   // R2
    {2'b01, 3'd3, 1'b0, 4'd3},   // R2
    {2'b01, 3'd7, 1'b0, 4'd7},   // R5
    {2'b01, 3'd0, 1'b1, 4'd0},   // R6
    {2'b10, 3'd4, 1'b0, 4'd4},   // R3
    {2'b10, 3'd0, 1'b1, 4'd10},  // R3
    {2'b10, 3'd0, 1'b0, 4'd0},   // R3
    {2'b11, 3'd6, 1'b1, 4'd6},   // R4
    {2'b11, 3'd6, 1'b0, 4'd0},   // R4
    {2'b11, 3'd0, 1'b1, 4'd0}    // R4
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic write_cfg(input logic [1:0] m, input logic [CNT_W-1:0] c);
    cfg_we = 1'b1; cfg_mode = m; cfg_count = c;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic start_access();
    acc_start = 1'b1;
    step();
    acc_start = 1'b0;
  endtask

  // Counts cycles after the start edge in which rdy_int_n reads 1.
  task automatic measure(output int waits);
    bit done = 1'b0;
    waits = 0;
    for (int i = 0; i < NEVER; i++) begin
      if (!done) begin
        #1;
        if (rdy_int_n == 1'b0) done = 1'b1;
        else begin
          waits++;
          @(posedge clk);
          #1;
        end
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int w;
    repeat (3) step();
    rst = 1'b0;
    step();

    // R8: idle ready, then a default access gives seven waits
    #1;
    chk(rdy_int_n == 1'b0, "R8 idle ready", rdy_int_n, 0);
    ext_rdy_n = 1'b1;
    step();
    start_access();
    measure(w);
    chk(w == 7, "R8 default count", w, 7);
    ext_rdy_n = 1'b0;
    step();

    // Table walk: R1 R2 R3 R4 R5 R6
    for (int k = 0; k < 12; k++) begin
      string tag;
      case (VEC[k][9:8])
        2'b00: tag = "R1 table";
        2'b01: tag = "R2 table";
        2'b10: tag = "R3 table";
        default: tag = "R4 table";
      endcase
      write_cfg(VEC[k][9:8], VEC[k][7:5]);
      ext_rdy_n = VEC[k][4];
      start_access();
      measure(w);
      chk(w == int'(VEC[k][3:0]), tag, w, int'(VEC[k][3:0]));
      ext_rdy_n = 1'b0;
      repeat (9) step();
    end

    // R1: output tracks a toggling external ready in the same cycle
    write_cfg(2'b00, 3'd6);
    start_access();
    for (int i = 0; i < 4; i++) begin
      ext_rdy_n = i[0];
      #1;
      chk(rdy_int_n == ext_rdy_n, "R1 follow", rdy_int_n, ext_rdy_n);
      step();
    end
    ext_rdy_n = 1'b0;

    // R3: counter done after 2, external ready arrives after 4
    write_cfg(2'b10, 3'd2);
    ext_rdy_n = 1'b1;
    start_access();
    repeat (3) step();
    ext_rdy_n = 1'b0;
    #1;
    chk(rdy_int_n == 1'b0, "R3 late ext", rdy_int_n, 0);
    step();

    // R7: rests at zero, restart reloads
    write_cfg(2'b01, 3'd4);
    start_access();
    repeat (2) step();
    start_access();
    measure(w);
    chk(w == 4, "R7 reload", w, 4);
    for (int i = 0; i < 5; i++) begin
      step();
      chk(rdy_int_n == 1'b0, "R7 rest", rdy_int_n, 0);
    end

    // R9: write during access keeps its count, next access uses new value
    write_cfg(2'b01, 3'd5);
    ext_rdy_n = 1'b1;
    start_access();
    #1;
    chk(rdy_int_n == 1'b1, "R9 first wait", rdy_int_n, 1);
    cfg_we = 1'b1; cfg_mode = 2'b00; cfg_count = 3'd1;
    ext_rdy_n = 1'b0;
    step();
    cfg_we = 1'b0;
    measure(w);
    chk(w == 4, "R9 mid write ignored", w + 1, 5);
    ext_rdy_n = 1'b0;
    step();
    start_access();
    measure(w);
    chk(w == 0, "R9 next access new mode", w, 0);

    // R9: write in the same cycle as start not used for that access
    write_cfg(2'b01, 3'd2);
    cfg_we = 1'b1; cfg_mode = 2'b01; cfg_count = 3'd6;
    acc_start = 1'b1;
    step();
    cfg_we = 1'b0; acc_start = 1'b0;
    measure(w);
    chk(w == 2, "R9 same cycle", w, 2);
    repeat (3) step();
    start_access();
    measure(w);
    chk(w == 6, "R9 following access", w, 6);

    // R10: synchronous reset aborts countdown and restores defaults
    write_cfg(2'b11, 3'd2);
    ext_rdy_n = 1'b1;
    write_cfg(2'b01, 3'd6);
    start_access();
    rst = 1'b1;
    #1;
    chk(rdy_int_n == 1'b1, "R10 before edge", rdy_int_n, 1);
    step();
    rst = 1'b0;
    #1;
    chk(rdy_int_n == 1'b0, "R10 after edge", rdy_int_n, 0);
    step();
    start_access();
    measure(w);
    chk(w == 7, "R10 default restored", w, 7);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule